// File: doc/BRIEF.md
# Dual-Read Single-Write Register File

This block is the general-purpose register store of a five-stage RISC pipeline. It holds thirty-two 32-bit registers. Two operand ports, A and B, are read in the decode stage, and the write-back stage updates one register per cycle. Both read ports and the write port can be used in the same clock cycle.

The block has no single three-port array. It keeps two identical two-port memory banks. Every write goes to both banks, and each bank serves one read port alone. A read is synchronous: on a rising edge with the port's enable high, the port captures its address and the stored word. The word then appears on the port's output until the next enabled edge. While the enable is low, the port holds its captured word, so a stalled pipeline sees steady operands. An output-enable input per port forces that port's output to zero without changing what it holds. Register 0 is hard-wired to zero: writes to it are discarded, and any read of it returns zero.

The block has no state machine. Each read port has two conditions: capturing on an enabled edge, and holding while the enable is low. The enable input alone picks between them.

Top module: `regfile_2r1w`

## Requirements
- R1: While reset (`rst_n` low) is asserted and after it is released, before any enabled read, both read outputs are 0.
- R2: A word written with `wr_en` high at a rising edge is returned by a read port that captures that register at any later enabled edge.
- R3: Ports A and B read different registers in the same cycle, each returning its own register's contents; every write is visible through both ports.
- R4: A read of register 0 returns 0 on either port, even after a write of a nonzero value to register 0.
- R5: When a port captures register N at the same edge that writes register N, the port returns the value held before that write; a capture at a later edge returns the new value.
- R6: While a port's read enable is low, its output keeps the last captured word, even when its address changes and the captured register is overwritten.
- R7: While a port's output enable is low, its output is 0; raising the output enable again shows the held word with no clock edge needed.
- R8: With `wr_en` low, the write address and data have no effect on any register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the read-port registers |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Register index to write |
| wr_data | input | 32 | Word to write |
| rd_a_en | input | 1 | Port A capture enable |
| rd_a_oe | input | 1 | Port A output enable |
| rd_a_addr | input | 5 | Port A register index |
| rd_a_data | output | 32 | Port A read word |
| rd_b_en | input | 1 | Port B capture enable |
| rd_b_oe | input | 1 | Port B output enable |
| rd_b_addr | input | 5 | Port B register index |
| rd_b_data | output | 32 | Port B read word |

## Verification
The hardest case to reach from the ports is a collision: the same edge both captures and overwrites one register, and the port must show the old word. The bench writes a known word, then in one cycle drives a read of that register and a write of a different word to it. It samples the old word after that edge and the new word after the next one. A second hard case is a stall during which the held register is overwritten. The bench drops the enable, moves the address, rewrites the captured register, and checks that the output does not change for several cycles.

// File: rtl/rf_pkg.sv
package rf_pkg;
    localparam int DEF_NUM_REGS = 32;
    localparam int DEF_DATA_W   = 32;
    localparam int NUM_RD_PORTS = 2;

    typedef enum logic {
        PORT_A = 1'b0,
        PORT_B = 1'b1
    } rd_port_e;
endpackage

// File: rtl/rf_wr_filter.sv
module rf_wr_filter #(
    parameter int ADDR_W = 5
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic              bank_we
);
    // register 0 is never stored
    always_comb begin
        bank_we = wr_en && (wr_addr != '0);
    end
endmodule

// File: rtl/rf_bank.sv
module rf_bank #(
    parameter int NUM_REGS = 32,
    parameter int DATA_W   = 32,
    localparam int ADDR_W  = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata_q,
    output logic [ADDR_W-1:0] raddr_q
);
    logic [DATA_W-1:0] mem [NUM_REGS];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // read word sampled before this edge's write lands: read-before-write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
            raddr_q <= '0;
        end else if (re) begin
            rdata_q <= mem[raddr];
            raddr_q <= raddr;
        end
    end
endmodule

// File: rtl/rf_port_out.sv
module rf_port_out #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5
) (
    input  logic              oe,
    input  logic [ADDR_W-1:0] addr_q,
    input  logic [DATA_W-1:0] data_q,
    output logic [DATA_W-1:0] data_o
);
    always_comb begin
        if (oe && (addr_q != '0)) begin
            data_o = data_q;
        end else begin
            data_o = '0;
        end
    end
endmodule

// File: rtl/regfile_2r1w.sv
module regfile_2r1w
    import rf_pkg::*;
#(
    parameter int NUM_REGS = DEF_NUM_REGS,
    parameter int DATA_W   = DEF_DATA_W,
    localparam int ADDR_W  = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_a_en,
    input  logic              rd_a_oe,
    input  logic [ADDR_W-1:0] rd_a_addr,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic              rd_b_en,
    input  logic              rd_b_oe,
    input  logic [ADDR_W-1:0] rd_b_addr,
    output logic [DATA_W-1:0] rd_b_data
);
    logic                    bank_we;
    logic [NUM_RD_PORTS-1:0] en_v;
    logic [NUM_RD_PORTS-1:0] oe_v;
    logic [ADDR_W-1:0]       addr_v  [NUM_RD_PORTS];
    logic [ADDR_W-1:0]       addrq_v [NUM_RD_PORTS];
    logic [DATA_W-1:0]       dataq_v [NUM_RD_PORTS];
    logic [DATA_W-1:0]       out_v   [NUM_RD_PORTS];

    always_comb begin
        en_v[PORT_A]   = rd_a_en;
        en_v[PORT_B]   = rd_b_en;
        oe_v[PORT_A]   = rd_a_oe;
        oe_v[PORT_B]   = rd_b_oe;
        addr_v[PORT_A] = rd_a_addr;
        addr_v[PORT_B] = rd_b_addr;
    end

    rf_wr_filter #(.ADDR_W(ADDR_W)) u_wr_filter (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .bank_we (bank_we)
    );

    // one bank copy per read port, all fed by the same write
    for (genvar p = 0; p < NUM_RD_PORTS; p++) begin : g_port
        rf_bank #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .we      (bank_we),
            .waddr   (wr_addr),
            .wdata   (wr_data),
            .re      (en_v[p]),
            .raddr   (addr_v[p]),
            .rdata_q (dataq_v[p]),
            .raddr_q (addrq_v[p])
        );

        rf_port_out #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_out (
            .oe     (oe_v[p]),
            .addr_q (addrq_v[p]),
            .data_q (dataq_v[p]),
            .data_o (out_v[p])
        );
    end

    assign rd_a_data = out_v[PORT_A];
    assign rd_b_data = out_v[PORT_B];
endmodule

// File: rtl/rf_checker.sv
module rf_checker #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_a_en,
    input logic              rd_a_oe,
    input logic [ADDR_W-1:0] rd_a_addr,
    input logic [DATA_W-1:0] rd_a_data,
    input logic              rd_b_en,
    input logic              rd_b_oe,
    input logic [ADDR_W-1:0] rd_b_addr,
    input logic [DATA_W-1:0] rd_b_data
);
    // R4
    a_zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_en && rd_a_addr == '0) |=> (rd_a_data == '0));

    // R4
    b_zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_b_en && rd_b_addr == '0) |=> (rd_b_data == '0));

    // R7
    a_oe_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_a_oe |-> (rd_a_data == '0));

    // R7
    b_oe_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_b_oe |-> (rd_b_data == '0));

    // R6
    a_stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_a_en && rd_a_oe) |=> (!rd_a_oe || $stable(rd_a_data)));

    // R6
    b_stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_b_en && rd_b_oe) |=> (!rd_b_oe || $stable(rd_b_data)));
endmodule

bind regfile_2r1w rf_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rf_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_a_en   (rd_a_en),
    .rd_a_oe   (rd_a_oe),
    .rd_a_addr (rd_a_addr),
    .rd_a_data (rd_a_data),
    .rd_b_en   (rd_b_en),
    .rd_b_oe   (rd_b_oe),
    .rd_b_addr (rd_b_addr),
    .rd_b_data (rd_b_data)
);

// File: tb/tb_regfile_2r1w.sv
module tb_regfile_2r1w;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        rd_a_en = 1'b0;
    logic        rd_a_oe = 1'b1;
    logic [4:0]  rd_a_addr = '0;
    logic [31:0] rd_a_data;
    logic        rd_b_en = 1'b0;
    logic        rd_b_oe = 1'b1;
    logic [4:0]  rd_b_addr = '0;
    logic [31:0] rd_b_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    regfile_2r1w dut (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_a_en(rd_a_en), .rd_a_oe(rd_a_oe), .rd_a_addr(rd_a_addr), .rd_a_data(rd_a_data),
        .rd_b_en(rd_b_en), .rd_b_oe(rd_b_oe), .rd_b_addr(rd_b_addr), .rd_b_data(rd_b_data)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // inputs change at the falling edge; outputs are sampled at the following falling edge
    task automatic tick();
        @(negedge clk);
    endtask

    task automatic idle();
        wr_en = 1'b0; rd_a_en = 1'b0; rd_b_en = 1'b0;
    endtask

    task automatic do_write(input logic [4:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick();
        idle();
    endtask

    task automatic do_read(input logic [4:0] a, input logic [4:0] b);
        rd_a_en = 1'b1; rd_a_addr = a;
        rd_b_en = 1'b1; rd_b_addr = b;
        tick();
        idle();
    endtask

    task automatic t_reset();
        #1;
        check("R1 port A in reset", rd_a_data, 32'h0);
        check("R1 port B in reset", rd_b_data, 32'h0);
        repeat (2) tick();
        rst_n = 1'b1;
        tick();
        check("R1 port A after reset", rd_a_data, 32'h0);
        check("R1 port B after reset", rd_b_data, 32'h0);
    endtask

    task automatic t_write_read();
        do_write(5'd5, 32'hA5A5_0001);
        do_write(5'd31, 32'h3131_FFFF);
        do_write(5'd1, 32'h0000_0011);
        do_read(5'd5, 5'd31);
        check("R2 port A reads r5", rd_a_data, 32'hA5A5_0001);
        check("R3 port B reads r31", rd_b_data, 32'h3131_FFFF);
        do_read(5'd31, 5'd5);
        check("R3 port A reads r31", rd_a_data, 32'h3131_FFFF);
        check("R3 port B reads r5", rd_b_data, 32'hA5A5_0001);
        do_read(5'd1, 5'd1);
        check("R2 port A reads r1", rd_a_data, 32'h0000_0011);
        check("R3 port B reads r1", rd_b_data, 32'h0000_0011);
    endtask

    task automatic t_zero_reg();
        do_write(5'd0, 32'hFFFF_FFFF);
        do_read(5'd0, 5'd0);
        check("R4 port A r0", rd_a_data, 32'h0);
        check("R4 port B r0", rd_b_data, 32'h0);
    endtask

    task automatic t_collision();
        do_write(5'd7, 32'h0000_0111);
        wr_en = 1'b1; wr_addr = 5'd7; wr_data = 32'h0000_0222;
        rd_a_en = 1'b1; rd_a_addr = 5'd7;
        rd_b_en = 1'b1; rd_b_addr = 5'd7;
        tick();
        idle();
        check("R5 port A old value", rd_a_data, 32'h0000_0111);
        check("R5 port B old value", rd_b_data, 32'h0000_0111);
        do_read(5'd7, 5'd7);
        check("R5 port A new value", rd_a_data, 32'h0000_0222);
        check("R5 port B new value", rd_b_data, 32'h0000_0222);
    endtask

    task automatic t_stall();
        do_read(5'd5, 5'd31);
        rd_a_addr = 5'd31; rd_b_addr = 5'd5;
        do_write(5'd5, 32'h5555_5555);
        for (int i = 0; i < 3; i++) begin
            check("R6 port A holds", rd_a_data, 32'hA5A5_0001);
            check("R6 port B holds", rd_b_data, 32'h3131_FFFF);
            tick();
        end
        do_read(5'd5, 5'd5);
        check("R6 port A after stall", rd_a_data, 32'h5555_5555);
    endtask

    task automatic t_oe();
        do_read(5'd31, 5'd7);
        rd_a_oe = 1'b0;
        #1;
        check("R7 port A masked", rd_a_data, 32'h0);
        check("R7 port B unaffected", rd_b_data, 32'h0000_0222);
        rd_b_oe = 1'b0;
        #1;
        check("R7 port B masked", rd_b_data, 32'h0);
        rd_a_oe = 1'b1; rd_b_oe = 1'b1;
        #1;
        check("R7 port A restored", rd_a_data, 32'h3131_FFFF);
        check("R7 port B restored", rd_b_data, 32'h0000_0222);
    endtask

    task automatic t_no_write();
        wr_en = 1'b0; wr_addr = 5'd31; wr_data = 32'hDEAD_BEEF;
        tick();
        wr_addr = 5'd1;
        tick();
        do_read(5'd31, 5'd1);
        check("R8 r31 untouched", rd_a_data, 32'h3131_FFFF);
        check("R8 r1 untouched", rd_b_data, 32'h0000_0011);
    endtask

    initial begin
        t_reset();
        t_write_read();
        t_zero_reg();
        t_collision();
        t_stall();
        t_oe();
        t_no_write();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule